// File: doc/BRIEF.md
# Synchronous Static Memory Bus Target

This block is the target side of a synchronous static memory bus, placed in an I/O FPGA behind a bus master. The master drives an address, two active-low chip selects, an active-low output enable, an active-low write enable and write data. The target samples all of these on the rising edge of the single bus clock. Every bus input passes through two register stages before any logic uses it. This gives a fixed input latency.

Each decoded access becomes exactly one transfer on an internal valid/ready request port. The transfer is either a register read or a register write. The master learns that the access is complete from a wait output. Wait stays high until two things are true: the internal side has accepted the request, and the minimum cycle length for the selected chip select has elapsed. The minimum length is set per chip select. Read data is held in a register and presented on the data output whenever a read strobe and a single chip select are seen. A drive-enable pin lets the pad-level tristate buffer follow the same condition.

The request port follows valid/ready rules. The target raises `req_valid_o` and holds it, with every request field stable, until `req_ready_i` is sampled high on a rising edge. That edge completes the transfer. The internal side may hold ready low for as long as it needs. Wait simply stays high for that time. For reads, `req_rdata_i` is captured on the same edge as the handshake.

Top module: `stmem_target`

## Requirements
- R1: An access is first seen on the third rising edge after the bus pins present it: two input register stages plus the state register. Both `bus_wait_o` and `req_valid_o` rise after that edge.
- R2: Only an access with exactly one chip select low is accepted. If no chip select is low, or both are low, the access is ignored: there is no request and wait stays low.
- R3: The request carries the sampled address, the write data and the chip-select index. Index 0 means `bus_cs_n_i[0]` is low; index 1 means `bus_cs_n_i[1]` is low.
- R4: With an immediate acknowledge, wait stays high for exactly the minimum for the selected chip select: 5 cycles for index 0 and 7 cycles for index 1, with the default parameters.
- R5: Suppose ready is first presented D cycles after valid rises, so the handshake falls on the (D+1)-th edge with valid high. Then wait stays high for max(minimum, D+2) cycles.
- R6: Each accepted access produces exactly one request. Valid and the request fields hold until the handshake.
- R7: A read returns the data captured at its handshake on `bus_data_o`. `bus_data_oe_o` is high only while the registered output enable and exactly one registered chip select are both low. It falls two edges after either one is released.
- R8: A low write enable makes the access a write (`req_write_o` = 1), even when output enable is also low. Otherwise the access is a read.
- R9: After wait falls, no further request is issued while the master keeps the same access on the pins. A new access needs a release first.
- R10: After reset, wait, valid and the data drive enable are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| bus_addr_i | input | ADDR_W | Bus address |
| bus_cs_n_i | input | 2 | Active-low chip selects |
| bus_oe_n_i | input | 1 | Active-low output enable (read strobe) |
| bus_we_n_i | input | 1 | Active-low write enable |
| bus_data_i | input | DATA_W | Write data from the master |
| bus_data_o | output | DATA_W | Read data toward the master |
| bus_data_oe_o | output | 1 | Drive enable for the data pad |
| bus_wait_o | output | 1 | Access in progress; master must extend the cycle |
| req_valid_o | output | 1 | Internal request valid |
| req_ready_i | input | 1 | Internal side accepts the request |
| req_write_o | output | 1 | 1 = write, 0 = read |
| req_sel_o | output | 1 | Chip-select index of the access |
| req_addr_o | output | ADDR_W | Request address |
| req_wdata_o | output | DATA_W | Request write data |
| req_rdata_i | input | DATA_W | Read data, sampled at the handshake |

## Verification
The bench builds the target with its default parameters: an 8-bit address, 16-bit data, and minimum lengths of 5 and 7 cycles. The acknowledge delay is swept from zero to eight cycles. This lets both chip selects show wait lengths set by the minimum and lengths set by the acknowledge, including the crossover where the two are equal. Random accesses also include both-low and none-low chip-select codes, and write-with-output-enable overlaps.

// File: rtl/stmem_pkg.sv
package stmem_pkg;
  localparam int CS_COUNT = 2;
  localparam int SEL_W    = 1;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUSY = 2'd1,
    ST_HOLD = 2'd2
  } acc_state_e;
endpackage

// File: rtl/stmem_sync2.sv
module stmem_sync2 #(
  parameter int            W       = 1,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= RST_VAL;
      stage2_q <= RST_VAL;
    end else begin
      stage1_q <= d_i;
      stage2_q <= stage1_q;
    end
  end

  assign q_o = stage2_q;
endmodule

// File: rtl/stmem_cs_decode.sv
module stmem_cs_decode
  import stmem_pkg::*;
#(
  parameter int MIN_CYC_A = 5,
  parameter int MIN_CYC_B = 7,
  parameter int CNT_W     = 3
) (
  input  logic [CS_COUNT-1:0] cs_n_i,
  output logic                hit_o,
  output logic [SEL_W-1:0]    sel_o,
  output logic [CNT_W-1:0]    min_o
);
  logic [CS_COUNT-1:0] active;
  logic [CNT_W-1:0]    min_tab [CS_COUNT];

  assign active = ~cs_n_i;
  assign hit_o  = $onehot(active);

  for (genvar g = 0; g < CS_COUNT; g++) begin : g_min
    if (g == 0) begin : g_first
      assign min_tab[g] = CNT_W'(MIN_CYC_A);
    end else begin : g_rest
      assign min_tab[g] = CNT_W'(MIN_CYC_B);
    end
  end

  always_comb begin
    sel_o = '0;
    for (int i = 0; i < CS_COUNT; i++) begin
      if (active[i]) sel_o = SEL_W'(i);
    end
  end

  assign min_o = min_tab[sel_o];
endmodule

// File: rtl/stmem_access_fsm.sv
module stmem_access_fsm
  import stmem_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              present_i,
  input  logic              write_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [CNT_W-1:0]  min_i,
  input  logic              req_ready_i,
  input  logic [DATA_W-1:0] req_rdata_i,
  output logic              req_valid_o,
  output logic              req_write_o,
  output logic [SEL_W-1:0]  req_sel_o,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic [DATA_W-1:0] req_wdata_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              wait_o
);
  acc_state_e        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  min_q;
  logic              acked_q;
  logic              valid_q;
  logic              write_q;
  logic [SEL_W-1:0]  sel_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;
  logic              wait_q;
  logic              hs;

  assign hs = valid_q && req_ready_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      min_q   <= '0;
      acked_q <= 1'b0;
      valid_q <= 1'b0;
      write_q <= 1'b0;
      sel_q   <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      wait_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (present_i) begin
            state_q <= ST_BUSY;
            valid_q <= 1'b1;
            write_q <= write_i;
            sel_q   <= sel_i;
            addr_q  <= addr_i;
            wdata_q <= wdata_i;
            min_q   <= min_i;
            cnt_q   <= CNT_W'(1);
            acked_q <= 1'b0;
            wait_q  <= 1'b1;
          end
        end
        ST_BUSY: begin
          if (hs) begin
            valid_q <= 1'b0;
            acked_q <= 1'b1;
            if (!write_q) rdata_q <= req_rdata_i;
          end
          if (cnt_q < min_q) cnt_q <= cnt_q + CNT_W'(1);
          if (acked_q && (cnt_q >= min_q)) begin
            state_q <= ST_HOLD;
            wait_q  <= 1'b0;
          end
        end
        ST_HOLD: begin
          if (!present_i) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_valid_o = valid_q;
  assign req_write_o = write_q;
  assign req_sel_o   = sel_q;
  assign req_addr_o  = addr_q;
  assign req_wdata_o = wdata_q;
  assign rdata_o     = rdata_q;
  assign wait_o      = wait_q;

  p_wait_min_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wait_q) |-> ($past(cnt_q) >= $past(min_q)));

  p_wait_covers_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> wait_q);

  p_valid_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !req_ready_i) |=> (valid_q && $stable(addr_q) && $stable(write_q)
                                    && $stable(wdata_q) && $stable(sel_q)));

  p_hold_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HOLD) |=> !$rose(valid_q));
endmodule

// File: rtl/stmem_target.sv
module stmem_target
  import stmem_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 16,
  parameter int MIN_CYC_A = 5,
  parameter int MIN_CYC_B = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr_i,
  input  logic [CS_COUNT-1:0] bus_cs_n_i,
  input  logic                bus_oe_n_i,
  input  logic                bus_we_n_i,
  input  logic [DATA_W-1:0]   bus_data_i,
  output logic [DATA_W-1:0]   bus_data_o,
  output logic                bus_data_oe_o,
  output logic                bus_wait_o,
  output logic                req_valid_o,
  input  logic                req_ready_i,
  output logic                req_write_o,
  output logic [SEL_W-1:0]    req_sel_o,
  output logic [ADDR_W-1:0]   req_addr_o,
  output logic [DATA_W-1:0]   req_wdata_o,
  input  logic [DATA_W-1:0]   req_rdata_i
);
  localparam int MIN_MAX = (MIN_CYC_A > MIN_CYC_B) ? MIN_CYC_A : MIN_CYC_B;
  localparam int CNT_W   = $clog2(MIN_MAX + 1);
  localparam int CTL_W   = CS_COUNT + 2;
  localparam int DAT_W   = ADDR_W + DATA_W;

  logic [CTL_W-1:0]    ctl_s;
  logic [DAT_W-1:0]    dat_s;
  logic [CS_COUNT-1:0] cs_n_s;
  logic                oe_n_s;
  logic                we_n_s;
  logic [ADDR_W-1:0]   addr_s;
  logic [DATA_W-1:0]   wdata_s;
  logic                cs_hit;
  logic [SEL_W-1:0]    cs_sel;
  logic [CNT_W-1:0]    cs_min;
  logic                present;

  stmem_sync2 #(.W(CTL_W), .RST_VAL({CTL_W{1'b1}})) u_ctl_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({bus_cs_n_i, bus_oe_n_i, bus_we_n_i}),
    .q_o   (ctl_s)
  );

  stmem_sync2 #(.W(DAT_W), .RST_VAL({DAT_W{1'b0}})) u_dat_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({bus_addr_i, bus_data_i}),
    .q_o   (dat_s)
  );

  assign {cs_n_s, oe_n_s, we_n_s} = ctl_s;
  assign {addr_s, wdata_s}        = dat_s;

  stmem_cs_decode #(.MIN_CYC_A(MIN_CYC_A), .MIN_CYC_B(MIN_CYC_B), .CNT_W(CNT_W)) u_dec (
    .cs_n_i (cs_n_s),
    .hit_o  (cs_hit),
    .sel_o  (cs_sel),
    .min_o  (cs_min)
  );

  assign present       = cs_hit && (!oe_n_s || !we_n_s);
  assign bus_data_oe_o = cs_hit && !oe_n_s;

  stmem_access_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .present_i   (present),
    .write_i     (!we_n_s),
    .addr_i      (addr_s),
    .wdata_i     (wdata_s),
    .sel_i       (cs_sel),
    .min_i       (cs_min),
    .req_ready_i (req_ready_i),
    .req_rdata_i (req_rdata_i),
    .req_valid_o (req_valid_o),
    .req_write_o (req_write_o),
    .req_sel_o   (req_sel_o),
    .req_addr_o  (req_addr_o),
    .req_wdata_o (req_wdata_o),
    .rdata_o     (bus_data_o),
    .wait_o      (bus_wait_o)
  );

  p_start_decoded_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_valid_o) |-> $past(cs_hit));

  p_start_raises_wait_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_valid_o) |-> $rose(bus_wait_o));
endmodule

// File: tb/stmem_target_bench.sv
module stmem_target_bench;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int MIN_A = 5;
  localparam int MIN_B = 7;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [1:0]    bus_cs_n = 2'b11;
  logic          bus_oe_n = 1'b1;
  logic          bus_we_n = 1'b1;
  logic [DW-1:0] bus_din = '0;
  logic [DW-1:0] bus_dout;
  logic          bus_doe;
  logic          bus_wait;
  logic          req_valid;
  logic          req_ready = 1'b0;
  logic          req_write;
  logic [0:0]    req_sel;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic [DW-1:0] req_rdata = '0;

  int total = 0;
  int failed = 0;
  int hs_cnt = 0;
  int ready_delay = 0;
  int vcnt = 0;
  int cycles = 0;
  logic          cap_write;
  logic [0:0]    cap_sel;
  logic [AW-1:0] cap_addr;
  logic [DW-1:0] cap_wdata;

  always #2 clk = ~clk;

  stmem_target #(.ADDR_W(AW), .DATA_W(DW), .MIN_CYC_A(MIN_A), .MIN_CYC_B(MIN_B)) u_stmem_target (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_addr_i    (bus_addr),
    .bus_cs_n_i    (bus_cs_n),
    .bus_oe_n_i    (bus_oe_n),
    .bus_we_n_i    (bus_we_n),
    .bus_data_i    (bus_din),
    .bus_data_o    (bus_dout),
    .bus_data_oe_o (bus_doe),
    .bus_wait_o    (bus_wait),
    .req_valid_o   (req_valid),
    .req_ready_i   (req_ready),
    .req_write_o   (req_write),
    .req_sel_o     (req_sel),
    .req_addr_o    (req_addr),
    .req_wdata_o   (req_wdata),
    .req_rdata_i   (req_rdata)
  );

  function automatic logic [DW-1:0] exp_rdata(input logic [AW-1:0] a, input logic s);
    return {a, ~a} ^ (s ? 16'hA55A : 16'h0FF0);
  endfunction

  function automatic int exp_wait(input logic s, input int d);
    int m;
    m = s ? MIN_B : MIN_A;
    return (d + 2 > m) ? d + 2 : m;
  endfunction

  // internal-side responder: ready after ready_delay cycles of valid
  always @(negedge clk) begin
    cycles++;
    if (req_valid && !req_ready) begin
      if (vcnt >= ready_delay) begin
        cap_write = req_write;
        cap_sel   = req_sel;
        cap_addr  = req_addr;
        cap_wdata = req_wdata;
        req_rdata = exp_rdata(req_addr, req_sel[0]);
        hs_cnt++;
        req_ready = 1'b1;
      end
      vcnt++;
    end else if (!req_valid) begin
      req_ready = 1'b0;
      vcnt = 0;
    end
  end

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic release_bus();
    bus_cs_n = 2'b11;
    bus_oe_n = 1'b1;
    bus_we_n = 1'b1;
  endtask

  task automatic run_access(input logic [1:0] csn, input bit we, input bit oe,
                            input logic [AW-1:0] a, input logic [DW-1:0] wd, input int d);
    int  hs0;
    int  k;
    int  len;
    bit  good;
    bit  seen;
    logic s;
    hs0  = hs_cnt;
    good = (csn == 2'b10 || csn == 2'b01) && (we || oe);
    s    = (csn == 2'b01);
    @(negedge clk);
    ready_delay = d;
    bus_cs_n = csn;
    bus_we_n = !we;
    bus_oe_n = !oe;
    bus_addr = a;
    bus_din  = wd;
    if (!good) begin
      seen = 1'b0;
      for (int i = 0; i < 12; i++) begin
        @(negedge clk);
        if (bus_wait || req_valid) seen = 1'b1;
      end
      chk(!seen && hs_cnt == hs0, "R2", "ignored access made activity", 32'(seen), 32'd0);
      release_bus();
      repeat (4) @(negedge clk);
      return;
    end
    k = 0;
    do begin
      @(negedge clk);
      k++;
    end while (!bus_wait && k < 10);
    chk(k == 3 && req_valid, "R1", "edges until access seen", k, 3);
    len = 0;
    while (bus_wait && len < 40) begin
      len++;
      @(negedge clk);
    end
    if (d + 2 <= (s ? MIN_B : MIN_A))
      chk(len == exp_wait(s, d), "R4", "wait length", len, exp_wait(s, d));
    else
      chk(len == exp_wait(s, d), "R5", "wait length", len, exp_wait(s, d));
    chk(hs_cnt == hs0 + 1, "R6", "requests per access", hs_cnt - hs0, 1);
    chk(cap_addr == a && cap_sel[0] == s, "R3", "request addr/sel",
        {cap_sel, cap_addr}, {s, a});
    chk(cap_write == we, "R8", "request direction", 32'(cap_write), 32'(we));
    if (we) begin
      chk(cap_wdata == wd, "R3", "request write data", cap_wdata, wd);
      chk(bus_doe == oe, "R7", "drive enable on write", 32'(bus_doe), 32'(oe));
    end else begin
      chk(bus_doe == 1'b1 && bus_dout == exp_rdata(a, s), "R7", "read data",
          {bus_doe, bus_dout}, {1'b1, exp_rdata(a, s)});
    end
    seen = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (bus_wait || req_valid) seen = 1'b1;
    end
    chk(!seen && hs_cnt == hs0 + 1, "R9", "activity while access held",
        32'(hs_cnt - hs0), 32'd1);
    release_bus();
    repeat (2) @(negedge clk);
    chk(bus_doe == 1'b0, "R7", "drive enable after release", 32'(bus_doe), 32'd0);
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(!bus_wait && !req_valid && !bus_doe, "R10", "reset outputs",
        {bus_wait, req_valid, bus_doe}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!bus_wait && !req_valid && !bus_doe, "R10", "idle after reset",
        {bus_wait, req_valid, bus_doe}, 32'd0);

    // directed corners
    run_access(2'b10, 1'b0, 1'b1, 8'h12, 16'h0000, 0);  // index 0 minimum
    run_access(2'b01, 1'b0, 1'b1, 8'h34, 16'h0000, 0);  // index 1 minimum
    run_access(2'b10, 1'b1, 1'b0, 8'h56, 16'hBEEF, 7);  // ack-dominated write
    run_access(2'b01, 1'b0, 1'b1, 8'h78, 16'h0000, 5);  // ack equals minimum
    run_access(2'b01, 1'b1, 1'b1, 8'h9A, 16'hC0DE, 1);  // write wins over read
    run_access(2'b00, 1'b0, 1'b1, 8'hBC, 16'h0000, 0);  // both selects low
    run_access(2'b11, 1'b0, 1'b1, 8'hDE, 16'h0000, 0);  // no select low
    run_access(2'b10, 1'b0, 1'b0, 8'hF0, 16'h0000, 0);  // no strobe

    for (int n = 0; n < 30; n++) begin
      int unsigned r;
      logic [1:0] csn;
      bit we;
      bit oe;
      r = $urandom % 8;
      csn = (r < 3) ? 2'b10 : (r < 6) ? 2'b01 : (r == 6) ? 2'b00 : 2'b11;
      we = 1'($urandom % 2);
      oe = we ? 1'($urandom % 2) : 1'b1;
      run_access(csn, we, oe, 8'($urandom), 16'($urandom), int'($urandom % 9));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, failed);
    $finish;
  end

  initial begin
    wait (cycles > 100000);
    total++;
    failed++;
    $display("FAIL watchdog: actual %0d expected below 100000 cycles", cycles);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, failed);
    $finish;
  end
endmodule